// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block is the first-level instruction cache of a fetch front end, together with the logic that forms the fetch address. A group-granular fetch pointer is kept in a register. On each clock the pointer takes one of three values. It takes a redirect target when a prediction or resolution source asks for one. Otherwise it steps forward by one 16-byte group when fetch is allowed to advance, and it holds in every other case. The array is read at the current pointer. The read returns a naturally aligned group of four 32-bit instructions, five predecode bits per instruction, and a hit flag.

The array holds 8 Kbytes in 256 direct-mapped lines of 32 bytes. The line index is taken from low-order address bits. Each line also stores 40 predecode bits. Its tag carries a mode bit that tells whether the line was filled while fetching in the privileged, physically addressed mode or in normal, virtually addressed mode. A line hits only when the fetch runs in the mode recorded in that bit. Lines are written whole from a refill port, and a flush input invalidates the entire array. The predictor, the decoder and the refill source lie outside the block.

Top module: `ifetch_cache`

## Requirements
- R1: While rst is high, and on the first cycle after it has been sampled high, fetch_pc equals RESET_PC (default 0), the fetch mode is normal, every line is invalid and fetch_hit is 0.
- R2: When redirect_valid is 0 and advance is 1 at a rising edge, fetch_pc after that edge equals the previous fetch_pc plus 16, modulo 2^32.
- R3: When redirect_valid is 1 at a rising edge, fetch_pc after that edge equals redirect_grp shifted left by 4 bits, whatever the value of advance.
- R4: When redirect_valid and advance are both 0 at a rising edge, fetch_pc keeps its value.
- R5: fetch_hit is 1 only when the line at index fetch_pc[12:5] is valid, its stored tag equals fetch_pc[31:13] and its stored mode bit equals the fetch mode. In every other case fetch_hit is 0.
- R6: Let word j of a line be refill_data[32j+31:32j] and its predecode field j be refill_pd[5j+4:5j]. The fetch then returns word 4*fetch_pc[4]+k on fetch_insns[32k+31:32k] and field 4*fetch_pc[4]+k on fetch_pd[5k+4:5k], for slots k = 0..3.
- R7: A refill_valid pulse without flush writes the whole line at index refill_line_addr[7:0]. It records the tag refill_line_addr[26:8] and the mode bit refill_priv, and it marks the line valid. The new contents are seen by fetches from the next cycle on.
- R8: A flush pulse invalidates every line, so fetch_hit is 0 on the next cycle. A refill presented in the same cycle as flush is discarded.
- R9: The fetch mode is priv_mode sampled at the rising edge that loads fetch_pc. A line filled with refill_priv = 1 hits only in privileged mode, and a line filled with refill_priv = 0 hits only in normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Allow the fetch pointer to step forward one group |
| redirect_valid | input | 1 | Load the fetch pointer from redirect_grp |
| redirect_grp | input | 28 | Redirect target as a 16-byte group address |
| priv_mode | input | 1 | Fetch mode for the next group: 1 means privileged physical, 0 means normal virtual |
| flush | input | 1 | Invalidate all lines |
| refill_valid | input | 1 | Write one whole line |
| refill_line_addr | input | 27 | Line address (byte address bits 31:5) of the refill |
| refill_priv | input | 1 | Mode bit stored with the refilled line |
| refill_data | input | 256 | Eight instruction words of the line, word 0 in the low bits |
| refill_pd | input | 40 | Eight 5-bit predecode fields, field 0 in the low bits |
| fetch_pc | output | 32 | Byte address of the current fetch group |
| fetch_hit | output | 1 | The current group is present for the current mode |
| fetch_insns | output | 128 | Four instructions of the group, slot 0 in the low bits |
| fetch_pd | output | 20 | Four predecode fields of the group, slot 0 in the low bits |

## Verification
The bench fills all 256 lines and then walks 512 consecutive groups. The walk would expose a pointer that skipped or repeated groups, a wrong index or tag slice, or a swapped half-line choice that delivers the other four words. Directed cases then probe several conflicts. A redirect arrives together with advance, where a design with the wrong priority would step forward instead. A fetch uses the same index under a different tag, which must miss. A line's mode bit and the fetch mode disagree in both directions, where a design that ignores the bit would report a false hit. A flush arrives together with a refill, where a design that lets the refill through would leave a valid line behind. A wrap at the top of the address space would reveal an increment carried at the wrong width.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    localparam int ADDR_W      = 32;
    localparam int CACHE_BYTES = 8192;
    localparam int LINE_BYTES  = 32;
    localparam int INSN_W      = 32;
    localparam int GROUP_INSNS = 4;
    localparam int PD_W        = 5;

    localparam int LINES       = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W       = $clog2(LINES);
    localparam int LINE_OFF    = $clog2(LINE_BYTES);
    localparam int GRP_BYTES   = GROUP_INSNS * INSN_W / 8;
    localparam int GRP_OFF     = $clog2(GRP_BYTES);
    localparam int GSEL_W      = LINE_OFF - GRP_OFF;
    localparam int TAG_W       = ADDR_W - IDX_W - LINE_OFF;
    localparam int LINE_WORDS  = LINE_BYTES * 8 / INSN_W;
    localparam int GRP_W       = ADDR_W - GRP_OFF;
    localparam int LADDR_W     = ADDR_W - LINE_OFF;
    localparam int LINE_DATA_W = LINE_WORDS * INSN_W;
    localparam int LINE_PD_W   = LINE_WORDS * PD_W;
    localparam int GRP_DATA_W  = GROUP_INSNS * INSN_W;
    localparam int GRP_PD_W    = GROUP_INSNS * PD_W;

    typedef logic [ADDR_W-1:0]      addr_t;
    typedef logic [GRP_W-1:0]       grp_t;
    typedef logic [LADDR_W-1:0]     laddr_t;
    typedef logic [IDX_W-1:0]       idx_t;
    typedef logic [TAG_W-1:0]       tag_t;
    typedef logic [GSEL_W-1:0]      gsel_t;
    typedef logic [LINE_DATA_W-1:0] line_data_t;
    typedef logic [LINE_PD_W-1:0]   line_pd_t;
    typedef logic [GRP_DATA_W-1:0]  grp_data_t;
    typedef logic [GRP_PD_W-1:0]    grp_pd_t;

    typedef enum logic { MODE_VIRT = 1'b0, MODE_PHYS = 1'b1 } fetch_mode_e;

    typedef struct packed {
        fetch_mode_e mode;
        tag_t        tag;
    } tag_entry_t;

    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        gsel_t gsel;
    } grp_fields_t;

    function automatic grp_fields_t split_grp(grp_t g);
        return grp_fields_t'(g);
    endfunction

    function automatic idx_t line_idx(laddr_t l);
        return l[IDX_W-1:0];
    endfunction

    function automatic tag_t line_tag(laddr_t l);
        return l[IDX_W +: TAG_W];
    endfunction

endpackage

// File: rtl/ifc_pc_gen.sv
module ifc_pc_gen
    import ifc_pkg::*;
#(
    parameter grp_t RESET_GRP = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        advance,
    input  logic        redirect_valid,
    input  grp_t        redirect_grp,
    input  logic        priv_mode,
    output grp_t        pc_grp,
    output fetch_mode_e mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_grp <= RESET_GRP;
            mode   <= MODE_VIRT;
        end else begin
            mode <= priv_mode ? MODE_PHYS : MODE_VIRT;
            if (redirect_valid) begin
                pc_grp <= redirect_grp;
            end else if (advance) begin
                pc_grp <= pc_grp + grp_t'(1);
            end
        end
    end

endmodule

// File: rtl/ifc_tag_store.sv
module ifc_tag_store
    import ifc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        wr_en,
    input  idx_t        wr_idx,
    input  tag_entry_t  wr_entry,
    input  idx_t        rd_idx,
    input  tag_t        cmp_tag,
    input  fetch_mode_e cmp_mode,
    output logic        hit
);

    logic [LINES-1:0] valid_q;
    tag_entry_t       tags_q [LINES];
    tag_entry_t       rd_entry;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags_q[wr_idx] <= wr_entry;
        end
    end

    always_comb begin
        rd_entry = tags_q[rd_idx];
        hit = valid_q[rd_idx] && (rd_entry.tag == cmp_tag) && (rd_entry.mode == cmp_mode);
    end

endmodule

// File: rtl/ifc_data_store.sv
module ifc_data_store
    import ifc_pkg::*;
(
    input  logic       clk,
    input  logic       wr_en,
    input  idx_t       wr_idx,
    input  line_data_t wr_data,
    input  line_pd_t   wr_pd,
    input  idx_t       rd_idx,
    input  gsel_t      rd_gsel,
    output grp_data_t  rd_insns,
    output grp_pd_t    rd_pd
);

    line_data_t data_q [LINES];
    line_pd_t   pd_q   [LINES];
    line_data_t line_data;
    line_pd_t   line_pd;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            pd_q[wr_idx]   <= wr_pd;
        end
    end

    assign line_data = data_q[rd_idx];
    assign line_pd   = pd_q[rd_idx];

    for (genvar k = 0; k < GROUP_INSNS; k++) begin : g_slot
        logic [$clog2(LINE_WORDS)-1:0] word_sel;
        assign word_sel = ($clog2(LINE_WORDS))'(int'(rd_gsel) * GROUP_INSNS + k);
        assign rd_insns[k*INSN_W +: INSN_W] = line_data[word_sel*INSN_W +: INSN_W];
        assign rd_pd[k*PD_W +: PD_W]        = line_pd[word_sel*PD_W +: PD_W];
    end

endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
    import ifc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        advance,
    input  logic                        redirect_valid,
    input  logic [ifc_pkg::GRP_W-1:0]   redirect_grp,
    input  logic                        priv_mode,
    input  logic                        flush,
    input  logic                        refill_valid,
    input  logic [ifc_pkg::LADDR_W-1:0] refill_line_addr,
    input  logic                        refill_priv,
    input  logic [ifc_pkg::LINE_DATA_W-1:0] refill_data,
    input  logic [ifc_pkg::LINE_PD_W-1:0]   refill_pd,
    output logic [ifc_pkg::ADDR_W-1:0]  fetch_pc,
    output logic                        fetch_hit,
    output logic [ifc_pkg::GRP_DATA_W-1:0] fetch_insns,
    output logic [ifc_pkg::GRP_PD_W-1:0]   fetch_pd
);

    localparam grp_t RESET_GRP = grp_t'(RESET_PC >> GRP_OFF);

    grp_t        pc_grp;
    fetch_mode_e mode;
    grp_fields_t fa;
    logic        refill_we;
    tag_entry_t  refill_entry;

    ifc_pc_gen #(.RESET_GRP(RESET_GRP)) pc_gen_i (
        .clk            (clk),
        .rst            (rst),
        .advance        (advance),
        .redirect_valid (redirect_valid),
        .redirect_grp   (redirect_grp),
        .priv_mode      (priv_mode),
        .pc_grp         (pc_grp),
        .mode           (mode)
    );

    assign fa        = split_grp(pc_grp);
    assign refill_we = refill_valid && !flush;
    assign refill_entry.tag  = line_tag(refill_line_addr);
    assign refill_entry.mode = refill_priv ? MODE_PHYS : MODE_VIRT;

    ifc_tag_store tag_i (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (refill_we),
        .wr_idx   (line_idx(refill_line_addr)),
        .wr_entry (refill_entry),
        .rd_idx   (fa.idx),
        .cmp_tag  (fa.tag),
        .cmp_mode (mode),
        .hit      (fetch_hit)
    );

    ifc_data_store data_i (
        .clk      (clk),
        .wr_en    (refill_we),
        .wr_idx   (line_idx(refill_line_addr)),
        .wr_data  (refill_data),
        .wr_pd    (refill_pd),
        .rd_idx   (fa.idx),
        .rd_gsel  (fa.gsel),
        .rd_insns (fetch_insns),
        .rd_pd    (fetch_pd)
    );

    assign fetch_pc = {pc_grp, {GRP_OFF{1'b0}}};

endmodule

// File: rtl/ifc_checker.sv
module ifc_checker
    import ifc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              advance,
    input logic              redirect_valid,
    input logic [GRP_W-1:0]  redirect_grp,
    input logic              flush,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              fetch_hit
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (fetch_pc == RESET_PC) && !fetch_hit);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (advance && !redirect_valid) |=> (fetch_pc == $past(fetch_pc) + ADDR_W'(GRP_BYTES)));

    assert_redirect_wins_R3: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> (fetch_pc == {$past(redirect_grp), {GRP_OFF{1'b0}}}));

    assert_hold_pc_R4: assert property (@(posedge clk) disable iff (rst)
        (!advance && !redirect_valid) |=> $stable(fetch_pc));

    assert_flush_miss_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !fetch_hit);

    assert_pc_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        fetch_pc[GRP_OFF-1:0] == '0);

endmodule

bind ifetch_cache ifc_checker #(.RESET_PC(RESET_PC)) chk_i (.*);

// File: tb/ifetch_cache_tb_top.sv
`timescale 1ns/1ps
module ifetch_cache_tb_top;
    import ifc_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   advance;
    logic                   redirect_valid;
    logic [GRP_W-1:0]       redirect_grp;
    logic                   priv_mode;
    logic                   flush;
    logic                   refill_valid;
    logic [LADDR_W-1:0]     refill_line_addr;
    logic                   refill_priv;
    logic [LINE_DATA_W-1:0] refill_data;
    logic [LINE_PD_W-1:0]   refill_pd;
    logic [ADDR_W-1:0]      fetch_pc;
    logic                   fetch_hit;
    logic [GRP_DATA_W-1:0]  fetch_insns;
    logic [GRP_PD_W-1:0]    fetch_pd;

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ifetch_cache dut_i (
        .clk(clk), .rst(rst), .advance(advance), .redirect_valid(redirect_valid),
        .redirect_grp(redirect_grp), .priv_mode(priv_mode), .flush(flush),
        .refill_valid(refill_valid), .refill_line_addr(refill_line_addr),
        .refill_priv(refill_priv), .refill_data(refill_data), .refill_pd(refill_pd),
        .fetch_pc(fetch_pc), .fetch_hit(fetch_hit), .fetch_insns(fetch_insns),
        .fetch_pd(fetch_pd)
    );

    function automatic logic [31:0] exp_word(logic [26:0] key, int j);
        return 32'({key, 3'(j)}) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [4:0] exp_pdf(logic [26:0] key, int j);
        return 5'(32'(key) * 3 + j);
    endfunction

    function automatic logic [255:0] line_of(logic [26:0] key);
        logic [255:0] d;
        for (int j = 0; j < 8; j++) d[j*32 +: 32] = exp_word(key, j);
        return d;
    endfunction

    function automatic logic [39:0] pd_of(logic [26:0] key);
        logic [39:0] p;
        for (int j = 0; j < 8; j++) p[j*5 +: 5] = exp_pdf(key, j);
        return p;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_group(string req, logic [31:0] pc, bit exp_hit, logic [26:0] key);
        logic [127:0] ei;
        logic [19:0]  ep;
        int g;
        g = int'(pc[4]);
        for (int k = 0; k < 4; k++) begin
            ei[k*32 +: 32] = exp_word(key, g*4 + k);
            ep[k*5 +: 5]   = exp_pdf(key, g*4 + k);
        end
        chk({req, " pc"}, 128'(fetch_pc), 128'(pc));
        chk({req, " hit"}, 128'(fetch_hit), 128'(exp_hit));
        if (exp_hit) begin
            chk({req, " insns R6"}, fetch_insns, ei);
            chk({req, " pd R6"}, 128'(fetch_pd), 128'(ep));
        end
    endtask

    task automatic refill(logic [26:0] laddr, logic [26:0] key, bit priv, bit with_flush);
        refill_valid     = 1'b1;
        refill_line_addr = laddr;
        refill_priv      = priv;
        refill_data      = line_of(key);
        refill_pd        = pd_of(key);
        flush            = with_flush;
        tick();
        refill_valid = 1'b0;
        flush        = 1'b0;
    endtask

    task automatic redirect_to(logic [31:0] pc, bit priv);
        redirect_valid = 1'b1;
        redirect_grp   = pc[31:4];
        priv_mode      = priv;
        tick();
        redirect_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc;
        rst = 1'b1; advance = 1'b0; redirect_valid = 1'b0; redirect_grp = '0;
        priv_mode = 1'b0; flush = 1'b0; refill_valid = 1'b0; refill_line_addr = '0;
        refill_priv = 1'b0; refill_data = '0; refill_pd = '0;
        tick(); tick(); tick();
        // R1: reset state
        chk("R1 pc", 128'(fetch_pc), 128'(0));
        chk("R1 hit", 128'(fetch_hit), 128'(0));
        rst = 1'b0;
        tick();
        chk("R1 pc after release", 128'(fetch_pc), 128'(0));

        // R7: fill every line with tag 8 (lines at 0x10000..0x11FFF)
        for (int i = 0; i < 256; i++) refill(27'h800 + 27'(i), 27'h800 + 27'(i), 1'b0, 1'b0);
        // R4: pointer held during fill; R5: index 0 holds tag 8, pc tag 0 misses
        check_group("R4/R5 held pc tag mismatch", 32'h0, 1'b0, '0);

        // R3 + R2 + R5 + R6: sweep 512 groups
        advance = 1'b1;
        redirect_to(32'h0001_0000, 1'b0);
        check_group("R3 sweep start", 32'h0001_0000, 1'b1, 27'h800);
        for (int n = 1; n < 512; n++) begin
            tick();
            pc = 32'h0001_0000 + 32'(n * 16);
            check_group("R2 R5 sweep", pc, 1'b1, pc[31:5]);
        end

        // R3: redirect wins over advance
        redirect_to(32'h0001_0130, 1'b0);
        check_group("R3 redirect priority", 32'h0001_0130, 1'b1, 27'h809);
        // R5: same index, other tag
        redirect_to(32'h0002_0130, 1'b0);
        check_group("R5 tag mismatch", 32'h0002_0130, 1'b0, '0);
        // R9: normal line fetched in privileged mode
        redirect_to(32'h0001_0130, 1'b1);
        check_group("R9 virt line in phys mode", 32'h0001_0130, 1'b0, '0);

        // R4: hold
        advance = 1'b0;
        tick(); tick();
        check_group("R4 hold", 32'h0001_0130, 1'b0, '0);

        // R7 R9: privileged refill of line 0x808
        refill(27'h808, 27'h808 ^ 27'h155, 1'b1, 1'b0);
        redirect_to(32'h0001_0100, 1'b1);
        check_group("R7 R9 phys line phys mode", 32'h0001_0100, 1'b1, 27'h808 ^ 27'h155);
        redirect_to(32'h0001_0110, 1'b0);
        check_group("R9 phys line virt mode", 32'h0001_0110, 1'b0, '0);

        // R8: flush with concurrent refill
        refill(27'h800, 27'h800, 1'b0, 1'b1);
        redirect_to(32'h0001_0000, 1'b0);
        check_group("R8 flush drops refill", 32'h0001_0000, 1'b0, '0);
        redirect_to(32'h0001_0040, 1'b0);
        check_group("R8 flush cleared others", 32'h0001_0040, 1'b0, '0);
        refill(27'h800, 27'h800, 1'b0, 1'b0);
        redirect_to(32'h0001_0010, 1'b0);
        check_group("R7 refill after flush", 32'h0001_0010, 1'b1, 27'h800);

        // R2: wrap at top of address space
        redirect_to(32'hFFFF_FFF0, 1'b0);
        chk("R3 top pc", 128'(fetch_pc), 128'(32'hFFFF_FFF0));
        advance = 1'b1;
        tick();
        chk("R2 wrap", 128'(fetch_pc), 128'(0));
        advance = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule